// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block watches a digitized sync-low level, one sample per pixel clock, together with a strobe that marks the start of every video line. In each line it adds up the clocks on which sync is low. A line whose low time passes a programmed threshold carries the vertical sync interval.

On that line the block raises VSYNC at once. It also sets the odd/even FIELD flag from where in the line the detection fell. VSYNC then lasts a programmed number of half-lines. Half-line boundaries come from the measured length of the previous line.

If no vertical sync is seen for a long run of lines, the block declares sync lost and pulses a reacquire request for the line-locking loops. It then generates VSYNC and FIELD itself at a programmed field length, so downstream timing keeps running without video. A genuine detection ends this free-run state.

Top module: `vsync_field_det`

## Requirements
- R1: The per-line low-time count is cleared on the line-start strobe and gains one on every clock with `sync_low_i` high, counting the strobe cycle itself. It saturates at its maximum.
- R2: In tracking, `vsync_o` rises in the very clock on which the low-time count first becomes greater than `thresh_i`. At most one detection is taken per line.
- R3: At each VSYNC rise, `field_o` takes its new value in that same clock. A detection at a line position (clocks since the strobe, strobe = 0) below half the previous line's length gives 0 (odd), otherwise 1 (even). `field_o` changes at no other time.
- R4: Half-line boundaries are the strobe clock and the clock at position half-line. VSYNC stays high until N boundaries have passed after the rise clock, and falls in the clock after the N-th. N = `vs_len_i`, with values below 3 treated as 3, so VSYNC always spans at least one full line.
- R5: A detection or free-run start arriving while VSYNC is high is ignored: no new rise, no field change, no restart of the line count.
- R6: Each VSYNC start clears a line counter, and each line strobe adds one to it. In tracking, when the count reaches LOST_LINES+LOST_EXTRA at a strobe, `lost_o` and a one-clock `reacq_o` both rise in the next clock, and the count clears.
- R7: While lost, at the strobe where the line count reaches `field_lines_i`, VSYNC starts on that strobe clock, `field_o` inverts, and the count clears.
- R8: A detection while lost starts VSYNC per R2 and R3, clears the count, and lowers `lost_o` in the next clock.
- R9: During reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_low_i | input | 1 | High while the sync level is low |
| line_start_i | input | 1 | One-clock strobe at each line start |
| thresh_i | input | CNT_W | Low-time detection threshold |
| field_lines_i | input | LINE_W | Free-run field length in lines |
| vs_len_i | input | HL_W | VSYNC length in half-lines |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | 0 odd field, 1 even field |
| lost_o | output | 1 | Vertical sync lost, free-running |
| reacq_o | output | 1 | One-clock reacquire request |

## Verification
The bench builds the block with LOST_LINES = 20 and LOST_EXTRA = 3 and drives 64-clock lines. It programs a 12-line free-run field. With these values, loss of sync, two free-run fields and recovery all fall within about ninety lines. That keeps the timing of the lost and free-run paths exact while the run stays short. The default counts cover full-size standards with the same logic.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  typedef enum logic {
    MODE_TRACK = 1'b0,
    MODE_FREE  = 1'b1
  } vsf_mode_e;

  localparam int unsigned VS_MIN_HALVES = 3;
endpackage

// File: rtl/vsf_line_timer.sv
module vsf_line_timer #(
  parameter int unsigned POS_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start_i,
  output logic tick_o,
  output logic first_half_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q, pos_cur, len_q, half;

  assign pos_cur      = line_start_i ? '0 : pos_q;
  assign half         = len_q >> 1;
  assign tick_o       = line_start_i || ((half != '0) && (pos_cur == half));
  assign first_half_o = pos_cur < half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      len_q <= '0;
    end else begin
      pos_q <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
      if (line_start_i) len_q <= pos_q;
    end
  end

  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_start_i) |-> (pos_q == POS_W'(1))); // R4
endmodule

// File: rtl/vsf_lowtime.sv
module vsf_lowtime #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start_i,
  input  logic             sync_low_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             det_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_cur, cnt_nxt;
  logic             fired_q;

  assign cnt_cur = line_start_i ? '0 : cnt_q;
  assign cnt_nxt = (sync_low_i && (cnt_cur != CNT_MAX)) ? cnt_cur + 1'b1 : cnt_cur;
  assign det_o   = sync_low_i && (cnt_nxt > thresh_i) && (line_start_i || !fired_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      fired_q <= (fired_q && !line_start_i) || det_o;
    end
  end

  AST_LOWCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_start_i) |-> (cnt_q <= CNT_W'(1))); // R1
endmodule

// File: rtl/vsf_pulse_gen.sv
module vsf_pulse_gen #(
  parameter int unsigned HL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic [HL_W-1:0] len_i,
  output logic            active_o
);
  import vsf_pkg::*;

  logic [HL_W:0]   len_eff, hcnt_inc;
  logic [HL_W-1:0] hcnt_q;
  logic            active_q;

  assign len_eff  = ({1'b0, len_i} < (HL_W+1)'(VS_MIN_HALVES)) ?
                    (HL_W+1)'(VS_MIN_HALVES) : {1'b0, len_i};
  assign hcnt_inc = {1'b0, hcnt_q} + 1'b1;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      hcnt_q   <= '0;
    end else if (active_q && tick_i) begin
      hcnt_q <= hcnt_inc[HL_W-1:0];
      if (hcnt_inc >= len_eff) active_q <= 1'b0;
    end
  end

  AST_NO_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> !start_i); // R5
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(tick_i)); // R4
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned POS_W      = 12,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned HL_W       = 5,
  parameter int unsigned LOST_LINES = 337,
  parameter int unsigned LOST_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_low_i,
  input  logic              line_start_i,
  input  logic [CNT_W-1:0]  thresh_i,
  input  logic [LINE_W-1:0] field_lines_i,
  input  logic [HL_W-1:0]   vs_len_i,
  output logic              vsync_o,
  output logic              field_o,
  output logic              lost_o,
  output logic              reacq_o
);
  import vsf_pkg::*;

  localparam logic [LINE_W:0] LOST_LIMIT = (LINE_W+1)'(LOST_LINES + LOST_EXTRA);

  logic            tick, first_half, det_raw, active;
  logic            det_ok, fr_fire, start, declare_lost, field_new;
  logic            field_q, reacq_q;
  logic [LINE_W-1:0] lines_q;
  logic [LINE_W:0] lines_nxt;
  vsf_mode_e       mode_q;

  vsf_line_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
    .tick_o(tick), .first_half_o(first_half)
  );

  vsf_lowtime #(.CNT_W(CNT_W)) u_low (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
    .sync_low_i(sync_low_i), .thresh_i(thresh_i), .det_o(det_raw)
  );

  vsf_pulse_gen #(.HL_W(HL_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
    .len_i(vs_len_i), .active_o(active)
  );

  assign lines_nxt    = {1'b0, lines_q} + 1'b1;
  assign det_ok       = det_raw && !active;
  assign fr_fire      = line_start_i && (mode_q == MODE_FREE) &&
                        (lines_nxt >= {1'b0, field_lines_i});
  assign start        = (det_raw || fr_fire) && !active;
  assign field_new    = det_ok ? !first_half : !field_q;
  assign declare_lost = line_start_i && (mode_q == MODE_TRACK) &&
                        (lines_nxt == LOST_LIMIT) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_TRACK;
      lines_q <= '0;
      field_q <= 1'b0;
      reacq_q <= 1'b0;
    end else begin
      reacq_q <= declare_lost;
      if (start) begin
        lines_q <= '0;
        field_q <= field_new;
        if (det_ok) mode_q <= MODE_TRACK;
      end else if (declare_lost) begin
        mode_q  <= MODE_FREE;
        lines_q <= '0;
      end else if (line_start_i && !lines_nxt[LINE_W]) begin
        lines_q <= lines_nxt[LINE_W-1:0];
      end
    end
  end

  assign vsync_o = active || start;
  assign field_o = start ? field_new : field_q;
  assign lost_o  = (mode_q == MODE_FREE);
  assign reacq_o = reacq_q;

  AST_REACQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reacq_q |=> !reacq_q); // R6
  AST_REACQ_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    reacq_q |-> lost_o); // R6
  AST_FIELD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != $past(field_q)) |-> $past(start)); // R3
  AST_LOST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_o) |-> $past(det_ok)); // R8
endmodule

// File: tb/vsync_field_det_tb_top.sv
module vsync_field_det_tb_top;
  localparam int LL = 64;
  localparam int K_RISE = 0, K_FALL = 1, K_FIELD = 2, K_LUP = 3, K_LDN = 4, K_REACQ = 5;

  typedef struct {
    int    kind;
    int    t;
    int    v;
    string req;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_low_i = 1'b0;
  logic        line_start_i = 1'b0;
  logic [11:0] thresh_i = 12'd20;
  logic [9:0]  field_lines_i = 10'd12;
  logic [4:0]  vs_len_i = 5'd13;
  logic        vsync_o, field_o, lost_o, reacq_o;

  int   n_tests = 0, n_fail = 0;
  int   cur_abs = -1;
  int   line_no = 0;
  bit   done = 1'b0;
  ev_t  exp_q[$];

  always #5 clk = ~clk;

  vsync_field_det #(.LOST_LINES(20), .LOST_EXTRA(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_low_i(sync_low_i), .line_start_i(line_start_i),
    .thresh_i(thresh_i), .field_lines_i(field_lines_i), .vs_len_i(vs_len_i),
    .vsync_o(vsync_o), .field_o(field_o), .lost_o(lost_o), .reacq_o(reacq_o)
  );

  function automatic int tick_after(int t0, int n);
    int t = t0;
    int k = 0;
    while (k < n) begin
      t++;
      if (t % (LL/2) == 0) k++;
    end
    return t + 1;
  endfunction

  task automatic push(int kind, int t, int v, string req);
    ev_t e;
    e.kind = kind; e.t = t; e.v = v; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(int kind, int t, int v);
    ev_t e;
    n_tests++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R5 unexpected event kind=%0d t=%0d v=%0d, expected none", kind, t, v);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.t != t || e.v != v) begin
        n_fail++;
        $display("FAIL %s event actual kind=%0d t=%0d v=%0d expected kind=%0d t=%0d v=%0d",
                 e.req, kind, t, v, e.kind, e.t, e.v);
      end
    end
  endtask

  // kind 0 normal line, 1 long low early (odd), 2 long low late (even)
  task automatic run_line(int kind);
    for (int c = 0; c < LL; c++) begin
      @(negedge clk);
      cur_abs = line_no * LL + c;
      line_start_i = (c == 0);
      case (kind)
        1:       sync_low_i = (c < 30);
        2:       sync_low_i = (c < 5) || (c >= 40 && c < 60);
        default: sync_low_i = (c < 5);
      endcase
    end
    line_no++;
  endtask

  task automatic run_lines(int n);
    for (int i = 0; i < n; i++) run_line(0);
  endtask

  // monitor: samples outputs 2 ns after each falling edge
  logic pv = 1'b0, pf = 1'b0, pl = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n && cur_abs >= 0 && !done) begin
      if (vsync_o && !pv) observe(K_RISE, cur_abs, int'(field_o));
      if (!vsync_o && pv) observe(K_FALL, cur_abs, 0);
      if (field_o != pf && !(vsync_o && !pv)) observe(K_FIELD, cur_abs, int'(field_o));
      if (lost_o && !pl) observe(K_LUP, cur_abs, 0);
      if (!lost_o && pl) observe(K_LDN, cur_abs, 0);
      if (reacq_o) observe(K_REACQ, cur_abs, 0);
      pv = vsync_o; pf = field_o; pl = lost_o;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing event: actual none, expected kind=%0d t=%0d",
               exp_q[0].req, exp_q[0].kind, exp_q[0].t);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t;
    repeat (4) @(negedge clk);
    #2;
    n_tests++;
    if ({vsync_o, field_o, lost_o, reacq_o} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R9 reset outputs actual %b expected 0000",
               {vsync_o, field_o, lost_o, reacq_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    run_lines(4);
    // R1 R2 R3: odd detection at position 20 of line 4
    t = 4 * LL + 20;
    push(K_RISE, t, 0, "R1,R2,R3");
    push(K_FALL, tick_after(t, 13), 0, "R4");
    run_line(1);
    run_line(1);   // R5: second detection line while VSYNC high, ignored
    run_lines(6);

    // R3: even detection at position 55 of line 12
    t = 12 * LL + 55;
    push(K_RISE, t, 1, "R1,R3");
    push(K_FALL, tick_after(t, 13), 0, "R4");
    run_line(2);
    run_lines(8);

    // R4: length below minimum is clamped to 3 half-lines
    vs_len_i = 5'd1;
    t = 21 * LL + 20;
    push(K_RISE, t, 0, "R2");
    push(K_FALL, tick_after(t, 3), 0, "R4");
    run_line(1);
    run_lines(2);
    vs_len_i = 5'd13;

    // R6: 23 line starts after line 21 -> lost at line 44
    push(K_LUP, 44 * LL + 1, 0, "R6");
    push(K_REACQ, 44 * LL + 1, 0, "R6");
    run_lines(32);   // lines 24..55

    // R7: free-run starts every 12 lines, field toggles
    t = 56 * LL;
    push(K_RISE, t, 1, "R7");
    push(K_FALL, tick_after(t, 13), 0, "R7");
    run_lines(12);   // lines 56..67
    t = 68 * LL;
    push(K_RISE, t, 0, "R7");
    push(K_FALL, tick_after(t, 13), 0, "R7");
    run_lines(8);    // lines 68..75

    // R8: detection while lost ends free-run
    t = 76 * LL + 20;
    push(K_RISE, t, 0, "R8");
    push(K_LDN, t + 1, 0, "R8");
    push(K_FALL, tick_after(t, 13), 0, "R8");
    run_line(1);
    run_lines(9);

    finish_run();
  end
endmodule